// File: doc/BRIEF.md
# MDIO management master

This block is a register-driven controller for the two-wire PHY management bus. Software programs four 32-bit registers (configuration, control, address and data). The block produces the management clock from the system clock, serialises each frame onto the data line through a separate output and output enable, and samples the line for read data. One register set serves both the short-address framing (start code 01) and the indirect extended framing (start code 00). The configuration register selects between the two.

A frame is never started by a dedicated "go" bit. Each frame starts as a side effect of a particular register write.
- In extended mode, writing the address register sends an address frame.
- In either mode, writing the data register sends a write frame.
- In either mode, writing the control register with its read bit set sends a read frame.

There are two busy flags. An address frame in flight shows as busy in the configuration register. A write or read frame in flight shows as busy in the data register. When a read ends, the returned value appears in the data register, and an error flag in the configuration register says whether the PHY answered.

The register port is a plain write strobe with a combinational read mux. It has no back-pressure. A write that would start a frame while one is running is dropped.

Top module: `mdio_master`

Register map (word address on `reg_addr`):
- 0 configuration: [7:0] divider D, [11:8] hold H, [12] extended mode, [13] address-frame busy (read only), [14] read error (read only).
- 1 control: [4:0] register number (short mode) or device address (extended mode), [9:5] PHY/port address, [15] read launch (reads back 0).
- 2 address: [15:0].
- 3 data: [15:0] value, [31] data-frame busy (read only).

## Requirements
- R1: After reset, all four registers read 0, and `mdc` and `mdio_oe` are low.
- R2: While a frame runs, `mdc` has a period of 2×(D+1) system clocks. `mdc` is low whenever no frame runs.
- R3: Configuration writes never start a frame. D, H and the mode bit read back as written.
- R4: Short-mode write frame, started by a data write. It is 32 ones, then 01, opcode 01, PHY address (5 bits, MSB first), register number (5 bits), 10, then the 16 data bits MSB first.
- R5: Short-mode read frame, started by a control write with bit 15 set. It uses opcode 10, and the master releases the line (`mdio_oe` low) for bit positions 46 to 63. The 16 bits sampled at positions 48 to 63 land in data[15:0].
- R6: In extended mode an address write sends 32 ones, 00, 00, port, device, 10, address. In short mode an address write only stores the value. Configuration bit 13 is set only during address frames, and data bit 31 only during write and read frames.
- R7: Extended-mode write and read frames use start code 00 with opcodes 01 and 11, and take port and device from the control register.
- R8: Each new output bit appears min(H, D) system clocks after the falling edge of `mdc`. Input is sampled on the rising edge.
- R9: Configuration bit 14 is set after a read if the PHY drove bit position 47 high. It is cleared when the next read starts.
- R10: Writes to control, address or data made while any frame runs are ignored, including their stored contents.
- R11: `mdio_oe` is low whenever no frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
A frame sequencer that loses its bit position would show a wrong or shifted frame at the pins. The scoreboard compares the whole 64-bit frame and its drive mask as soon as the 64th rising edge is seen, so this shows up within one frame.

A hold counter that is off by one shows as a wrong delay between the clock fall and the data change, measured at the preamble-to-start transition. Errors in busy or launch decoding show within one register read after the write: a stuck or swapped busy flag, a dropped or extra frame, or register contents changed by a write that should have been ignored.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_HI_IDX  = 46;  // first turnaround bit
  localparam int TA_LO_IDX  = 47;  // second turnaround bit
  localparam int DATA_IDX   = 48;  // first payload bit
  localparam int FLD_W      = 5;
  localparam int PA_LSB     = 5;
  localparam int RD_BIT     = 15;
  localparam int DBUSY_BIT  = 31;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_ADDR = 2'd2;
  localparam logic [1:0] RA_DATA = 2'd3;

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic c45, input frame_kind_e kind,
      input logic [FLD_W-1:0] pa, input logic [FLD_W-1:0] ra,
      input logic [15:0] payload);
    logic [1:0]  st, op, ta;
    logic [15:0] d;
    st = c45 ? 2'b00 : 2'b01;
    if (kind == FK_READ)       op = c45 ? 2'b11 : 2'b10;
    else if (kind == FK_WRITE) op = 2'b01;
    else                       op = 2'b00;
    ta = (kind == FK_READ) ? 2'b11 : 2'b10;
    d  = (kind == FK_READ) ? 16'h0000 : payload;
    return {{PRE_BITS{1'b1}}, st, op, pa, ra, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             edge_now;

  assign edge_now = run && (cnt == div);
  assign rise_p   = edge_now && !mdc;
  assign fall_p   = edge_now && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  frame_kind_e           launch_kind,
  input  logic [FRAME_BITS-1:0] launch_frame,
  input  logic [DIV_W-1:0]      div,
  input  logic [HOLD_W-1:0]     hold,
  input  logic                  rise_p,
  input  logic                  fall_p,
  input  logic                  mdio_i,
  output logic                  active,
  output frame_kind_e           kind_q,
  output logic                  done,
  output logic [15:0]           rd_data,
  output logic                  rd_err,
  output logic                  mdio_o,
  output logic                  mdio_oe
);
  localparam int CW = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;

  logic [FRAME_BITS-1:0] frame_sh;
  logic [IDX_W-1:0]      idx, idx_inc;
  logic                  pending;
  logic [CW-1:0]         hcnt, hold_eff, div_x, hold_x;
  logic [15:0]           rd_sh;

  // hold never reaches the next rising edge: clamp to the divider
  assign div_x    = CW'(div);
  assign hold_x   = CW'(hold);
  assign hold_eff = (hold_x > div_x) ? div_x : hold_x;
  assign idx_inc  = idx + IDX_W'(1);
  assign done     = active && fall_p && (int'(idx) == FRAME_BITS - 1);
  assign rd_data  = rd_sh;

  function automatic logic drives_at(input frame_kind_e k, input logic [IDX_W-1:0] i);
    return !(k == FK_READ && int'(i) >= TA_HI_IDX);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      kind_q   <= FK_ADDR;
      frame_sh <= '0;
      idx      <= '0;
      pending  <= 1'b0;
      hcnt     <= '0;
      rd_sh    <= '0;
      rd_err   <= 1'b0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (launch && !active) begin
      active   <= 1'b1;
      kind_q   <= launch_kind;
      frame_sh <= launch_frame;
      idx      <= '0;
      pending  <= 1'b0;
      hcnt     <= '0;
      mdio_o   <= launch_frame[FRAME_BITS-1];
      mdio_oe  <= 1'b1;
      if (launch_kind == FK_READ) rd_err <= 1'b0;
    end else if (active) begin
      if (rise_p && kind_q == FK_READ) begin
        if (int'(idx) == TA_LO_IDX) rd_err <= mdio_i;
        if (int'(idx) >= DATA_IDX)  rd_sh  <= {rd_sh[14:0], mdio_i};
      end
      if (done) begin
        active  <= 1'b0;
        pending <= 1'b0;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (fall_p) begin
        idx <= idx_inc;
        if (hold_eff == '0) begin
          mdio_o   <= frame_sh[FRAME_BITS-2];
          frame_sh <= frame_sh << 1;
          mdio_oe  <= drives_at(kind_q, idx_inc);
        end else begin
          pending <= 1'b1;
          hcnt    <= hold_eff;
        end
      end else if (pending) begin
        if (hcnt == CW'(1)) begin
          pending  <= 1'b0;
          mdio_o   <= frame_sh[FRAME_BITS-2];
          frame_sh <= frame_sh << 1;
          mdio_oe  <= drives_at(kind_q, idx);
        end else begin
          hcnt <= hcnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [1:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  seq_busy,
  input  frame_kind_e           seq_kind,
  input  logic                  seq_done,
  input  logic [15:0]           seq_rdata,
  input  logic                  seq_rderr,
  output logic [DIV_W-1:0]      div,
  output logic [HOLD_W-1:0]     hold,
  output logic                  launch,
  output frame_kind_e           launch_kind,
  output logic [FRAME_BITS-1:0] launch_frame,
  output logic                  addr_busy,
  output logic                  data_busy
);
  localparam int HOLD_LSB  = DIV_W;
  localparam int C45_BIT   = DIV_W + HOLD_W;
  localparam int ABUSY_BIT = C45_BIT + 1;
  localparam int ERR_BIT   = C45_BIT + 2;

  logic             c45_q, err_q;
  logic [FLD_W-1:0] pa_q, ra_q, pa_sel, ra_sel;
  logic [15:0]      addr_q, data_q;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[31:16], wdata[14:10]};
  assign addr_busy = seq_busy && (seq_kind == FK_ADDR);
  assign data_busy = seq_busy && (seq_kind != FK_ADDR);

  // launch decode: each frame type is a side effect of one register write
  always_comb begin
    launch      = 1'b0;
    launch_kind = FK_WRITE;
    if (we && !seq_busy) begin
      case (addr)
        RA_CTRL: if (wdata[RD_BIT]) begin launch = 1'b1; launch_kind = FK_READ; end
        RA_ADDR: if (c45_q)         begin launch = 1'b1; launch_kind = FK_ADDR; end
        RA_DATA:                    begin launch = 1'b1; launch_kind = FK_WRITE; end
        default: ;
      endcase
    end
  end

  assign pa_sel = (addr == RA_CTRL) ? wdata[PA_LSB +: FLD_W] : pa_q;
  assign ra_sel = (addr == RA_CTRL) ? wdata[FLD_W-1:0]       : ra_q;
  assign launch_frame = build_frame(c45_q, launch_kind, pa_sel, ra_sel, wdata[15:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      hold   <= '0;
      c45_q  <= 1'b0;
      pa_q   <= '0;
      ra_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (we) begin
        case (addr)
          RA_CFG: begin
            div   <= wdata[DIV_W-1:0];
            hold  <= wdata[HOLD_LSB +: HOLD_W];
            c45_q <= wdata[C45_BIT];
          end
          RA_CTRL: if (!seq_busy) begin
            pa_q <= wdata[PA_LSB +: FLD_W];
            ra_q <= wdata[FLD_W-1:0];
          end
          RA_ADDR: if (!seq_busy) addr_q <= wdata[15:0];
          RA_DATA: if (!seq_busy) data_q <= wdata[15:0];
          default: ;
        endcase
      end
      if (seq_done && seq_kind == FK_READ) begin
        data_q <= seq_rdata;
        err_q  <= seq_rderr;
      end
      if (launch && launch_kind == FK_READ) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CFG: begin
        rdata[DIV_W-1:0]          = div;
        rdata[HOLD_LSB +: HOLD_W] = hold;
        rdata[C45_BIT]            = c45_q;
        rdata[ABUSY_BIT]          = addr_busy;
        rdata[ERR_BIT]            = err_q;
      end
      RA_CTRL: begin
        rdata[PA_LSB +: FLD_W] = pa_q;
        rdata[FLD_W-1:0]       = ra_q;
      end
      RA_ADDR: rdata[15:0] = addr_q;
      default: begin
        rdata[15:0]      = data_q;
        rdata[DBUSY_BIT] = data_busy;
      end
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  seq_active, seq_done, seq_rderr, launch;
  logic                  rise_p, fall_p, addr_busy, data_busy;
  frame_kind_e           seq_kind, launch_kind;
  logic [FRAME_BITS-1:0] launch_frame;
  logic [15:0]           seq_rdata;
  logic [DIV_W-1:0]      div;
  logic [HOLD_W-1:0]     hold;

  mdio_regfile #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .seq_busy(seq_active), .seq_kind(seq_kind), .seq_done(seq_done),
    .seq_rdata(seq_rdata), .seq_rderr(seq_rderr),
    .div(div), .hold(hold), .launch(launch), .launch_kind(launch_kind),
    .launch_frame(launch_frame), .addr_busy(addr_busy), .data_busy(data_busy)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(seq_active), .div(div),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
  );

  mdio_frame_seq #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_kind(launch_kind),
    .launch_frame(launch_frame), .div(div), .hold(hold),
    .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
    .active(seq_active), .kind_q(seq_kind), .done(seq_done),
    .rd_data(seq_rdata), .rd_err(seq_rderr),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       seq_active,
  input logic       addr_busy,
  input logic       data_busy
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> !mdio_oe); // R11
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> !mdc); // R2
  AST_MDC_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
  AST_BUSY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_busy, data_busy})); // R6
  AST_CFG_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && !seq_active) |=> !seq_active); // R3
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && $past(seq_active)) |-> ($stable(addr_busy) && $stable(data_busy))); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .seq_active(seq_active),
  .addr_busy(addr_busy), .data_busy(data_busy)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i, phy_drive = 1'b1;

  always #2.5 clk = ~clk;  // 200 MHz
  assign mdio_i = mdio_oe ? mdio_o : phy_drive;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    int          div;
    int          hold;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_checks = 0, n_err = 0, total_rises = 0;
  int          cur_div = 0, cur_hold = 0;
  bit          cur_c45 = 1'b0, done_flag = 1'b0;
  logic [15:0] phy_resp = 16'h0;
  logic        phy_ta_bad = 1'b0;
  logic [31:0] v;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] r);
    @(negedge clk);
    reg_addr = a;
    #1 r = reg_rdata;
  endtask

  task automatic set_cfg(input int d, input int h, input bit c45);
    cur_div = d; cur_hold = h; cur_c45 = c45;
    wr(2'd0, (32'(c45) << 12) | (32'(h) << 8) | 32'(d));
  endtask

  // kind: 0 address, 1 write, 2 read
  task automatic expect_frame(input int kind, input logic [4:0] pa, input logic [4:0] ra,
                              input logic [15:0] d, input string tag);
    exp_t e;
    logic [1:0] st, op;
    st = cur_c45 ? 2'b00 : 2'b01;
    op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (cur_c45 ? 2'b11 : 2'b10);
    e.bits = {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
    e.oe   = (kind == 2) ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    e.div  = cur_div;
    e.hold = (cur_hold > cur_div) ? cur_div : cur_hold;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic wait_idle();
    logic [31:0] c, d;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, c); rd(2'd3, d);
      if (!c[13] && !d[31]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor + PHY model
  initial begin
    int nrise = 0, cyc = 0, fall_cyc = 0, r0 = 0, per = 0, hold_meas = -1;
    logic [63:0] bits = '0, oev = '0;
    logic pm = 1'b0, po = 1'b0;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (!mdc && pm) fall_cyc = cyc;
      if (po && !mdio_o && mdio_oe && nrise == 32) hold_meas = cyc - fall_cyc;
      if (mdc && !pm) begin
        bits[63-nrise] = mdio_o;
        oev[63-nrise]  = mdio_oe;
        if (nrise == 0) r0 = cyc;
        if (nrise == 1) per = cyc - r0;
        nrise++;
        total_rises++;
        if (nrise == 46)                   phy_drive = 1'b1;
        else if (nrise == 47)              phy_drive = phy_ta_bad;
        else if (nrise >= 48 && nrise < 64) phy_drive = phy_resp[63-nrise];
        else                                phy_drive = 1'b1;
        if (nrise == 64) begin
          if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected frame", bits, 0);
          end else begin
            e = q.pop_front();
            chk((oev == e.oe) && ((bits & e.oe) == (e.bits & e.oe)), e.tag, "frame bits",
                bits & oev, e.bits & e.oe);
            chk(per == 2 * (e.div + 1), "R2", "mdc period", per, 2 * (e.div + 1));
            chk(hold_meas == e.hold, "R8", "hold delay", hold_meas, e.hold);
          end
          nrise = 0; hold_meas = -1; phy_drive = 1'b1;
        end
      end
      pm = mdc; po = mdio_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    int r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 32'd0, "R1", "register after reset", v, 0);
    end
    chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);

    // R3 config write only
    set_cfg(1, 0, 0);
    r = total_rises;
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    chk(v == 32'h0000_0001, "R3", "config readback", v, 1);
    chk(total_rises == r, "R3", "no clock after config write", total_rises, r);
    // R6: short-mode address write only stores
    wr(2'd2, 32'h0000_1234);
    repeat (20) @(negedge clk);
    rd(2'd2, v);
    chk(v == 32'h1234, "R6", "address stored in short mode", v, 32'h1234);
    chk(total_rises == r, "R6", "no frame from short-mode address write", total_rises, r);

    // R4 short write
    wr(2'd1, (5 << 5) | 3);
    expect_frame(1, 5'd5, 5'd3, 16'hA5C3, "R4");
    wr(2'd3, 32'h0000_A5C3);
    rd(2'd3, v);
    chk(v[31] == 1'b1, "R6", "data busy during write", v[31], 1);
    rd(2'd0, v);
    chk(v[13] == 1'b0, "R6", "config busy clear during write", v[13], 0);
    wait_idle();
    chk(!mdio_oe, "R11", "oe low after frame", mdio_oe, 0);

    // R8 hold timing
    set_cfg(5, 3, 0);
    expect_frame(1, 5'd5, 5'd3, 16'h00FF, "R8");
    wr(2'd3, 32'h0000_00FF);
    wait_idle();
    set_cfg(5, 15, 0);
    expect_frame(1, 5'd5, 5'd3, 16'h3C3C, "R8");
    wr(2'd3, 32'h0000_3C3C);
    wait_idle();

    // R5 short read
    set_cfg(1, 0, 0);
    phy_resp = 16'h1234; phy_ta_bad = 1'b0;
    expect_frame(2, 5'd7, 5'd2, 16'h0, "R5");
    wr(2'd1, (1 << 15) | (7 << 5) | 2);
    wait_idle();
    rd(2'd3, v);
    chk(v == 32'h1234, "R5", "read data", v, 32'h1234);
    rd(2'd0, v);
    chk(v[14] == 1'b0, "R9", "no error on good read", v[14], 0);

    // R9 error and clear
    phy_resp = 16'h5555; phy_ta_bad = 1'b1;
    expect_frame(2, 5'd7, 5'd2, 16'h0, "R9");
    wr(2'd1, (1 << 15) | (7 << 5) | 2);
    wait_idle();
    rd(2'd0, v);
    chk(v[14] == 1'b1, "R9", "error set", v[14], 1);
    phy_resp = 16'h9A9A; phy_ta_bad = 1'b0;
    expect_frame(2, 5'd7, 5'd2, 16'h0, "R9");
    wr(2'd1, (1 << 15) | (7 << 5) | 2);
    rd(2'd0, v);
    chk(v[14] == 1'b0, "R9", "error cleared at read start", v[14], 0);
    wait_idle();
    rd(2'd3, v);
    chk(v == 32'h9A9A, "R5", "second read data", v, 32'h9A9A);

    // R6 extended address frame
    set_cfg(1, 1, 1);
    wr(2'd1, (2 << 5) | 1);
    expect_frame(0, 5'd2, 5'd1, 16'hBEEF, "R6");
    wr(2'd2, 32'h0000_BEEF);
    rd(2'd0, v);
    chk(v[13] == 1'b1, "R6", "config busy during address frame", v[13], 1);
    rd(2'd3, v);
    chk(v[31] == 1'b0, "R6", "data busy clear during address frame", v[31], 0);
    // R10 writes while busy
    wr(2'd3, 32'h0000_7777);
    wr(2'd2, 32'h0000_1111);
    wr(2'd1, (1 << 15) | (31 << 5) | 31);
    wait_idle();
    rd(2'd3, v);
    chk(v == 32'h9A9A, "R10", "data unchanged", v, 32'h9A9A);
    rd(2'd2, v);
    chk(v == 32'hBEEF, "R10", "address unchanged", v, 32'hBEEF);
    rd(2'd1, v);
    chk(v == 32'h41, "R10", "control unchanged", v, 32'h41);

    // R7 extended write and read
    expect_frame(1, 5'd2, 5'd1, 16'h0F0F, "R7");
    wr(2'd3, 32'h0000_0F0F);
    rd(2'd3, v);
    chk(v[31] == 1'b1, "R7", "data busy in extended write", v[31], 1);
    wait_idle();
    phy_resp = 16'hCAFE;
    expect_frame(2, 5'd2, 5'd1, 16'h0, "R7");
    wr(2'd1, (1 << 15) | (2 << 5) | 1);
    wait_idle();
    rd(2'd3, v);
    chk(v == 32'hCAFE, "R7", "extended read data", v, 32'hCAFE);
    chk(q.size() == 0, "R4", "all expected frames seen", q.size(), 0);
    chk(!mdio_oe && !mdc, "R11", "idle pins at end", {mdc, mdio_oe}, 0);
    done_flag = 1'b1;
    report();
  end
endmodule